// File: doc/BRIEF.md
# CPU Exception and Interrupt Controller

This block is the exception-handling slice of the system coprocessor in a 32-bit MIPS-style core. It holds the status, cause, exception-PC and processor-ID registers. When the pipeline reports a synchronous exception, or when an enabled hardware interrupt is pending, the block records the cause and the restart address, pushes the two-bit enable/mode stack in the status register, and hands back a one-cycle redirect to the exception vector. A boot-ROM vector or a RAM vector is picked by the boot-exception-vector status bit.

Interrupt sources enter as level event lines. Each rising edge latches a bit in a pending register. A mask register selects which pending bits may interrupt. A small register bus reads and writes both registers. The core reads and writes the coprocessor registers through a single-cycle move port.

Top module: `cpu_exc_ctrl`

## Requirements
- R1: After reset, SR reads 0x10600000, Cause and EPC read 0, the processor-ID register reads 0x00000002, redirPc is 0xBFC00000, redirValid is 0, and the pending and mask registers read 0.
- R2: If cop2Strap is 1 during reset, SR also has bit 30 set after reset, so it reads 0x50600000.
- R3: An exception accepted at a clock edge writes Cause as (slot flag << 30) | (old Cause AND 0x300) | cause value. The slot flag is excSlot for a synchronous exception and 0 for an interrupt. All other old Cause bits are discarded.
- R4: On an accepted exception, EPC takes curPc − 4 if the slot flag is 1, and curPc otherwise.
- R5: In the cycle after an accepted exception, redirValid is 1 for exactly one cycle. redirPc is then 0xBFC00180 if the old SR bit 22 was 1, and 0x80000080 if it was 0.
- R6: On an accepted exception, SR[5:2] takes the old SR[3:0], SR[1:0] become 0, and SR[31:6] keep their values.
- R7: A hardware interrupt is accepted when (pending AND mask) is nonzero and SR bit 0 and SR bit 10 are both 1. It is taken with cause value 0x400 and a slot flag of 0.
- R8: If excReq and an interrupt condition occur in the same cycle, the synchronous request is taken with its own cause, and the pending bits stay set.
- R9: A rising edge on irqSrc[i] sets pending bit i. A bus write to address 0 clears each pending bit where the written data is 0 and leaves bits where it is 1. A set beats a clear in the same cycle. Holding a source high does not set the bit again. Address 1 is the mask register, which is fully read/write.
- R10: The move port selects with copSel: 0 is SR, 1 is Cause, 2 is EPC, 3 is the processor ID. copRdata shows the selected register in the same cycle. A write takes effect at the clock edge. A write to the processor ID is ignored. An exception in the same cycle overrides a move-port write to SR, Cause or EPC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cop2Strap | input | 1 | Sets SR bit 30 at reset when 1 |
| curPc | input | 32 | PC of the instruction being excepted |
| excReq | input | 1 | Synchronous exception request |
| excCode | input | 32 | Cause value ORed into Cause |
| excSlot | input | 1 | Faulting instruction sits in a branch delay slot |
| redirValid | output | 1 | One-cycle redirect strobe |
| redirPc | output | 32 | Redirect / vector address |
| copWe | input | 1 | Move-port write enable |
| copSel | input | 2 | Move-port register select |
| copWdata | input | 32 | Move-port write data |
| copRdata | output | 32 | Move-port read data |
| irqSrc | input | NSRC | Interrupt event lines |
| busWe | input | 1 | Register-bus write enable |
| busAddr | input | 1 | 0 pending, 1 mask |
| busWdata | input | NSRC | Register-bus write data |
| busRdata | output | NSRC | Register-bus read data |

## Verification
The in-line assertions check the status push, the EPC-versus-slot-flag relation, and the legality of the redirect vector on every cycle. They also check that pending bits never drop without a bus write. Only the bench scenarios can show the rest. These are the reset and strap values, the Cause composition across every stack nibble, vector and slot combination, and the interrupt gate on both enable bits. The bench also covers priority against a simultaneous synchronous request, the rule that a set beats a clear, and the ignored processor-ID write.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  localparam logic [1:0] SEL_SR    = 2'd0;
  localparam logic [1:0] SEL_CAUSE = 2'd1;
  localparam logic [1:0] SEL_EPC   = 2'd2;
  localparam logic [1:0] SEL_PRID  = 2'd3;

  localparam logic [31:0] VEC_RESET   = 32'hBFC0_0000;
  localparam logic [31:0] VEC_BOOTEXC = 32'hBFC0_0180;
  localparam logic [31:0] VEC_RAMEXC  = 32'h8000_0080;
  localparam logic [31:0] IRQ_CODE    = 32'h0000_0400;
  localparam logic [31:0] SWI_KEEP    = 32'h0000_0300;

  typedef struct packed {
    logic excTake;
    logic isIrq;
    logic wrSr;
    logic wrCause;
    logic wrEpc;
  } dpStrobe_t;
endpackage

// File: rtl/exc_irq_regs.sv
module exc_irq_regs #(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] irqSrc,
  input  logic            busWe,
  input  logic            busAddr,
  input  logic [NSRC-1:0] busWdata,
  output logic [NSRC-1:0] busRdata,
  output logic            irqHit
);
  logic [NSRC-1:0] pendQ;
  logic [NSRC-1:0] maskQ;
  logic [NSRC-1:0] srcPrev;
  logic            pendWr;

  assign pendWr = busWe && (busAddr == 1'b0);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic riseI;
    assign riseI = irqSrc[i] & ~srcPrev[i];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcPrev[i] <= 1'b0;
        pendQ[i]   <= 1'b0;
      end else begin
        srcPrev[i] <= irqSrc[i];
        if (riseI)
          pendQ[i] <= 1'b1;
        else if (pendWr)
          pendQ[i] <= pendQ[i] & busWdata[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      maskQ <= '0;
    else if (busWe && busAddr)
      maskQ <= busWdata;
  end

  assign busRdata = busAddr ? maskQ : pendQ;
  assign irqHit   = |(pendQ & maskQ);

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendWr |=> ((pendQ & $past(pendQ)) == $past(pendQ)));
endmodule

// File: rtl/exc_control.sv
module exc_control
  import exc_ctrl_pkg::*;
(
  input  logic       excReq,
  input  logic       irqHit,
  input  logic       srIe,
  input  logic       srImBit,
  input  logic       copWe,
  input  logic [1:0] copSel,
  output dpStrobe_t  strb
);
  logic irqReq;

  assign irqReq = irqHit & srIe & srImBit;

  always_comb begin
    strb.excTake = excReq | irqReq;
    strb.isIrq   = irqReq & ~excReq;
    strb.wrSr    = copWe && (copSel == SEL_SR)    && !strb.excTake;
    strb.wrCause = copWe && (copSel == SEL_CAUSE) && !strb.excTake;
    strb.wrEpc   = copWe && (copSel == SEL_EPC)   && !strb.excTake;
  end
endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_ctrl_pkg::*;
#(
  parameter logic [31:0] RESET_SR = 32'h1060_0000,
  parameter logic [31:0] PRID_VAL = 32'h0000_0002,
  parameter int          STRAP_BIT = 30,
  parameter int          BEV_BIT   = 22
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cop2Strap,
  input  logic [31:0] curPc,
  input  logic [31:0] excCode,
  input  logic        excSlot,
  input  dpStrobe_t   strb,
  input  logic [1:0]  copSel,
  input  logic [31:0] copWdata,
  output logic [31:0] copRdata,
  output logic        srIe,
  output logic        srImBit,
  output logic [31:0] redirPc,
  output logic        redirValid
);
  localparam logic [31:0] STRAP_MASK = 32'h1 << STRAP_BIT;

  logic [31:0] srQ, causeQ, epcQ;
  logic [31:0] codeEff;
  logic        slotEff;
  logic [31:0] causeNext, epcNext, srPush, vecNext;

  always_comb begin
    codeEff   = strb.isIrq ? IRQ_CODE : excCode;
    slotEff   = strb.isIrq ? 1'b0 : excSlot;
    causeNext = ({31'b0, slotEff} << 30) | (causeQ & SWI_KEEP) | codeEff;
    epcNext   = slotEff ? (curPc - 32'd4) : curPc;
    srPush    = {srQ[31:6], srQ[3:0], 2'b00};
    vecNext   = srQ[BEV_BIT] ? VEC_BOOTEXC : VEC_RAMEXC;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srQ        <= RESET_SR | (cop2Strap ? STRAP_MASK : 32'h0);
      causeQ     <= '0;
      epcQ       <= '0;
      redirPc    <= VEC_RESET;
      redirValid <= 1'b0;
    end else begin
      redirValid <= strb.excTake;
      if (strb.excTake) begin
        srQ     <= srPush;
        causeQ  <= causeNext;
        epcQ    <= epcNext;
        redirPc <= vecNext;
      end else begin
        if (strb.wrSr)    srQ    <= copWdata;
        if (strb.wrCause) causeQ <= copWdata;
        if (strb.wrEpc)   epcQ   <= copWdata;
      end
    end
  end

  always_comb begin
    case (copSel)
      SEL_SR:    copRdata = srQ;
      SEL_CAUSE: copRdata = causeQ;
      SEL_EPC:   copRdata = epcQ;
      default:   copRdata = PRID_VAL;
    endcase
  end

  assign srIe    = srQ[0];
  assign srImBit = srQ[10];

  // R6
  sr_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.excTake |=> (srQ[1:0] == 2'b00) && (srQ[5:2] == $past(srQ[3:0]))
                     && (srQ[31:6] == $past(srQ[31:6])));

  // R5
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |-> (redirPc == VEC_BOOTEXC) || (redirPc == VEC_RAMEXC));

  // R4
  epc_plain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (redirValid && !causeQ[30]) |-> (epcQ == $past(curPc)));

  // R4
  epc_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (redirValid && causeQ[30]) |-> (epcQ == $past(curPc) - 32'd4));
endmodule

// File: rtl/cpu_exc_ctrl.sv
module cpu_exc_ctrl
  import exc_ctrl_pkg::*;
#(
  parameter int          NSRC     = 11,
  parameter logic [31:0] RESET_SR = 32'h1060_0000,
  parameter logic [31:0] PRID_VAL = 32'h0000_0002
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cop2Strap,
  input  logic [31:0]     curPc,
  input  logic            excReq,
  input  logic [31:0]     excCode,
  input  logic            excSlot,
  output logic            redirValid,
  output logic [31:0]     redirPc,
  input  logic            copWe,
  input  logic [1:0]      copSel,
  input  logic [31:0]     copWdata,
  output logic [31:0]     copRdata,
  input  logic [NSRC-1:0] irqSrc,
  input  logic            busWe,
  input  logic            busAddr,
  input  logic [NSRC-1:0] busWdata,
  output logic [NSRC-1:0] busRdata
);
  dpStrobe_t strb;
  logic      irqHit, srIe, srImBit;

  exc_irq_regs #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rstN(rstN), .irqSrc(irqSrc), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqHit(irqHit)
  );

  exc_control u_ctl (
    .excReq(excReq), .irqHit(irqHit), .srIe(srIe), .srImBit(srImBit),
    .copWe(copWe), .copSel(copSel), .strb(strb)
  );

  exc_datapath #(.RESET_SR(RESET_SR), .PRID_VAL(PRID_VAL)) u_dp (
    .clk(clk), .rstN(rstN), .cop2Strap(cop2Strap), .curPc(curPc),
    .excCode(excCode), .excSlot(excSlot), .strb(strb), .copSel(copSel),
    .copWdata(copWdata), .copRdata(copRdata), .srIe(srIe),
    .srImBit(srImBit), .redirPc(redirPc), .redirValid(redirValid)
  );
endmodule

// File: tb/cpu_exc_ctrl_bench.sv
`timescale 1ns/1ps
module cpu_exc_ctrl_bench;
  localparam int NSRC = 11;

  logic clk = 1'b0;
  logic rstN, cop2Strap, excReq, excSlot, copWe, busWe, busAddr, redirValid;
  logic [31:0] curPc, excCode, copWdata, copRdata, redirPc;
  logic [1:0]  copSel;
  logic [NSRC-1:0] irqSrc, busWdata, busRdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cpu_exc_ctrl #(.NSRC(NSRC)) u_cpu_exc_ctrl (
    .clk(clk), .rstN(rstN), .cop2Strap(cop2Strap), .curPc(curPc),
    .excReq(excReq), .excCode(excCode), .excSlot(excSlot),
    .redirValid(redirValid), .redirPc(redirPc), .copWe(copWe),
    .copSel(copSel), .copWdata(copWdata), .copRdata(copRdata),
    .irqSrc(irqSrc), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic copRd(logic [1:0] sel, output logic [31:0] v);
    copSel = sel;
    #0.5;
    v = copRdata;
  endtask

  task automatic copWr(logic [1:0] sel, logic [31:0] v);
    copWe = 1'b1; copSel = sel; copWdata = v;
    step();
    copWe = 1'b0;
  endtask

  task automatic busRd(logic a, output logic [NSRC-1:0] v);
    busAddr = a;
    #0.5;
    v = busRdata;
  endtask

  task automatic busWr(logic a, logic [NSRC-1:0] v);
    busWe = 1'b1; busAddr = a; busWdata = v;
    step();
    busWe = 1'b0;
  endtask

  task automatic doReset(logic strap);
    rstN = 1'b0; cop2Strap = strap;
    step(); step();
    rstN = 1'b1; cop2Strap = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] v, srW, oldC, code, pc;
    logic [NSRC-1:0] b;
    rstN = 1'b0; cop2Strap = 1'b0; curPc = '0; excReq = 1'b0; excCode = '0;
    excSlot = 1'b0; copWe = 1'b0; copSel = '0; copWdata = '0; irqSrc = '0;
    busWe = 1'b0; busAddr = 1'b0; busWdata = '0;
    @(negedge clk);

    // R1 reset values
    doReset(1'b0);
    copRd(2'd0, v); chk("R1 sr", v, 32'h1060_0000);
    copRd(2'd1, v); chk("R1 cause", v, 32'h0);
    copRd(2'd2, v); chk("R1 epc", v, 32'h0);
    copRd(2'd3, v); chk("R1 prid", v, 32'h2);
    chk("R1 redirPc", redirPc, 32'hBFC0_0000);
    chk("R1 redirValid", {31'b0, redirValid}, 32'h0);
    busRd(1'b0, b); chk("R1 pending", {21'b0, b}, 32'h0);
    busRd(1'b1, b); chk("R1 mask", {21'b0, b}, 32'h0);

    // R2 strap
    doReset(1'b1);
    copRd(2'd0, v); chk("R2 sr strap", v, 32'h5060_0000);
    doReset(1'b0);
    copRd(2'd0, v); chk("R2 sr nostrap", v, 32'h1060_0000);

    // R3 R4 R5 R6 sweep over stack nibble, BEV, slot, old cause
    for (int bev = 0; bev < 2; bev++)
      for (int slot = 0; slot < 2; slot++)
        for (int nib = 0; nib < 16; nib++)
          for (int oc = 0; oc < 2; oc++) begin
            srW  = 32'h1000_0030 | (32'(bev) << 22) | 32'(nib);
            oldC = oc ? 32'hFFFF_FFFF : 32'h0000_0240;
            code = 32'((nib * 4 + oc * 8) & 8'h7C);
            pc   = 32'h8001_0000 + 32'(nib * 64 + slot * 16 + bev * 4096 + oc * 4);
            copWr(2'd0, srW);
            copWr(2'd1, oldC);
            excReq = 1'b1; excCode = code; excSlot = slot[0]; curPc = pc;
            step();
            excReq = 1'b0;
            chk("R5 valid", {31'b0, redirValid}, 32'h1);
            chk("R5 vector", redirPc, bev ? 32'hBFC0_0180 : 32'h8000_0080);
            copRd(2'd1, v);
            chk("R3 cause", v, (32'(slot) << 30) | (oldC & 32'h300) | code);
            copRd(2'd2, v);
            chk("R4 epc", v, slot ? pc - 32'd4 : pc);
            copRd(2'd0, v);
            chk("R6 sr", v, (srW & ~32'h3F) | (32'(nib) << 2));
            step();
            chk("R5 pulse", {31'b0, redirValid}, 32'h0);
          end

    // R9 pending and mask registers
    doReset(1'b0);
    busWr(1'b1, 11'h5A5);
    busRd(1'b1, b); chk("R9 mask rw", {21'b0, b}, 32'h5A5);
    busWr(1'b1, 11'h000);
    irqSrc[0] = 1'b1; step();
    busRd(1'b0, b); chk("R9 rise sets", {21'b0, b}, 32'h1);
    busWr(1'b0, 11'h000);
    step(); step();
    busRd(1'b0, b); chk("R9 held no reset", {21'b0, b}, 32'h0);
    irqSrc[0] = 1'b0; irqSrc[3] = 1'b1; step();
    busWr(1'b0, 11'h7FF);
    busRd(1'b0, b); chk("R9 write one keeps", {21'b0, b}, 32'h8);
    irqSrc[1] = 1'b1;
    busWr(1'b0, 11'h000);
    busRd(1'b0, b); chk("R9 set beats clear", {21'b0, b}, 32'h2);
    irqSrc = '0;
    busWr(1'b0, 11'h000);

    // R7 interrupt gating
    busWr(1'b1, 11'h004);
    irqSrc[2] = 1'b1; step();
    step();
    chk("R7 no take sr0 low", {31'b0, redirValid}, 32'h0);
    copWr(2'd0, 32'h1060_0001);
    step();
    chk("R7 no take sr10 low", {31'b0, redirValid}, 32'h0);
    copWr(2'd0, 32'h1060_0401);
    curPc = 32'h8002_0040;
    step();
    chk("R7 irq taken", {31'b0, redirValid}, 32'h1);
    chk("R7 irq vector", redirPc, 32'hBFC0_0180);
    copRd(2'd1, v); chk("R7 irq cause", v, 32'h400);
    copRd(2'd2, v); chk("R7 irq epc", v, 32'h8002_0040);
    copRd(2'd0, v); chk("R7 irq sr", v, 32'h1060_0404);
    step();
    chk("R7 irq once", {31'b0, redirValid}, 32'h0);

    // R8 priority
    copWr(2'd0, 32'h1020_0401);
    excReq = 1'b1; excCode = 32'h24; excSlot = 1'b1; curPc = 32'h8003_0010;
    step();
    excReq = 1'b0; excSlot = 1'b0;
    copRd(2'd1, v); chk("R8 sync cause wins", v, 32'h4000_0024);
    copRd(2'd2, v); chk("R8 epc", v, 32'h8003_000C);
    chk("R8 vector", redirPc, 32'h8000_0080);
    busRd(1'b0, b); chk("R8 pending kept", {21'b0, b}, 32'h4);
    irqSrc = '0;

    // R10 move port
    copWr(2'd3, 32'hDEAD_BEEF);
    copRd(2'd3, v); chk("R10 prid ignored", v, 32'h2);
    copWr(2'd2, 32'h0000_1234);
    copRd(2'd2, v); chk("R10 epc write", v, 32'h1234);
    copWr(2'd1, 32'h0000_0300);
    copRd(2'd1, v); chk("R10 cause write", v, 32'h300);
    copWe = 1'b1; copSel = 2'd2; copWdata = 32'hDEAD_0000;
    excReq = 1'b1; excCode = 32'h10; curPc = 32'h0000_0100;
    step();
    copWe = 1'b0; excReq = 1'b0;
    copRd(2'd2, v); chk("R10 exception beats write", v, 32'h100);
    copRd(2'd1, v); chk("R3 swi bits kept", v, 32'h310);

    finishRun();
  end
endmodule